// File: doc/BRIEF.md
# Byte-Serial Fetch-Execute Sequencer

This block is a minimal control unit for a segmented 16-bit machine. It understands two instructions: a store of the accumulator's low byte to memory and a halt. Instruction bytes are pulled one at a time over a byte-wide memory port. Each byte costs one clock with the read strobe raised, and the instruction pointer advances after every byte.

A code address is formed as segment times sixteen plus offset, truncated to 20 bits. A store is recognised as opcode 88h followed by the addressing byte 07h. It then takes a third clock, a write cycle aimed at data segment : base register, and afterwards fetching resumes at the next code offset. Opcode F4h stops the unit. Any other byte in either fetch position also stops it and sets a trap flag.

The register values are taken from input ports while reset is held. Reset is synchronous and active low.

Top module: `bytestep_seq`

## Requirements
- R1: While `rst_n` is low, a rising clock edge loads CS, IP, DS, BX and the accumulator low byte from the `init_*` ports and clears `halted` and `illegal`. The first cycle after reset is released is an opcode fetch at CS:IP.
- R2: A physical address equals (segment × 16 + offset) mod 2^20. For example, 1000h:0005h gives 10005h.
- R3: A fetch cycle lasts one clock with `mem_rd`=1, `mem_wr`=0 and `mem_addr`=CS:IP. The byte on `mem_rdata` is taken at the closing clock edge, and IP then increases by 1.
- R4: The byte pair 88h, 07h causes exactly three cycles: an opcode fetch, an addressing-byte fetch, and one write clock. The write clock has `mem_wr`=1, `mem_rd`=0, `mem_addr`=DS:BX and `mem_wdata`=AL.
- R5: The cycle after a store's write clock is an opcode fetch at the offset that follows the addressing byte. The write does not move IP.
- R6: Opcode F4h costs one fetch cycle. From the next clock on, `halted`=1 and neither strobe is raised until reset.
- R7: An opcode other than 88h or F4h sets `illegal` and `halted` after its fetch. Both stay high with no strobes until reset.
- R8: After 88h, an addressing byte other than 07h sets `illegal` and `halted`, and no write cycle is issued.
- R9: IP wraps from FFFFh to 0000h when it is incremented.
- R10: Physical address sums that reach 2^20 wrap to the low 20 bits. For example, FFFFh:0010h gives 00000h.
- R11: `mem_rd` and `mem_wr` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_cs | input | 16 | Code segment loaded during reset |
| init_ip | input | 16 | Instruction pointer loaded during reset |
| init_ds | input | 16 | Data segment loaded during reset |
| init_bx | input | 16 | Base register loaded during reset |
| init_al | input | 8 | Accumulator low byte loaded during reset |
| mem_addr | output | 20 | Physical address of the current bus cycle |
| mem_rdata | input | 8 | Byte returned by memory during a read cycle |
| mem_rd | output | 1 | Read strobe, one clock per fetched byte |
| mem_wr | output | 1 | Write strobe, one clock per store |
| mem_wdata | output | 8 | Byte written during a write cycle |
| halted | output | 1 | The unit has stopped issuing bus cycles |
| illegal | output | 1 | The unit stopped on an unrecognised byte |

## Verification
The assertions assume that reset is held low from time zero until at least one clock edge has passed. They also assume that memory answers a read within the same clock in which the strobe is high, since the unit has no wait states.

The bench releases reset only after two clock edges. It drives `mem_rdata` from its byte model at the falling edge, using the address the unit presents, so the returned byte is stable before the sampling edge. Each program is built to end in a halt or a trap, which keeps every run inside the halt and trap behaviour that the properties describe.

// File: rtl/bseq_pkg.sv
// Shared definitions for the byte-serial sequencer: control states and the
// byte codes the decoder recognises. Assumes 8-bit instruction bytes.
package bseq_pkg;

    typedef enum logic [1:0] {
        ST_FETCH_OP   = 2'd0,
        ST_FETCH_MODE = 2'd1,
        ST_STORE      = 2'd2,
        ST_STOP       = 2'd3
    } seq_state_e;

    localparam logic [7:0] OP_STORE_BYTE = 8'h88;
    localparam logic [7:0] MODE_AL_TO_BX = 8'h07;
    localparam logic [7:0] OP_STOP       = 8'hF4;

endpackage

// File: rtl/bseq_phys_addr.sv
// Forms a physical address from a segment and an offset: the segment is
// shifted left by SHIFT bits and the offset is added. The result is truncated
// to ADDR_W bits. Assumes ADDR_W >= SEG_W and ADDR_W >= OFF_W.
module bseq_phys_addr #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 20,
    parameter int SHIFT  = 4
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);

    logic [ADDR_W-1:0] seg_wide;
    logic [ADDR_W-1:0] off_wide;

    // Widen both operands, then add modulo 2^ADDR_W.
    always_comb begin
        seg_wide = ADDR_W'(seg) << SHIFT;
        off_wide = ADDR_W'(off);
        phys     = seg_wide + off_wide;
    end

endmodule

// File: rtl/bseq_regs.sv
// Architectural registers of the sequencer: CS, IP, DS, BX and the
// accumulator low byte. All of them load from the init ports while reset is
// low. Only IP changes afterwards, stepping by one (wrapping) on ip_step.
module bseq_regs #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  init_cs,
    input  logic [OFF_W-1:0]  init_ip,
    input  logic [SEG_W-1:0]  init_ds,
    input  logic [OFF_W-1:0]  init_bx,
    input  logic [DATA_W-1:0] init_al,
    input  logic              ip_step,
    output logic [SEG_W-1:0]  cs_q,
    output logic [OFF_W-1:0]  ip_q,
    output logic [SEG_W-1:0]  ds_q,
    output logic [OFF_W-1:0]  bx_q,
    output logic [DATA_W-1:0] al_q
);

    // Segment, base and accumulator: loaded at reset, held afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= init_cs;
            ds_q <= init_ds;
            bx_q <= init_bx;
            al_q <= init_al;
        end
    end

    // Instruction pointer: loaded at reset, advanced once per fetched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q <= init_ip;
        end else if (ip_step) begin
            ip_q <= ip_q + OFF_W'(1);
        end
    end

endmodule

// File: rtl/bseq_ctrl.sv
// Machine-cycle controller. It walks through the opcode fetch, the
// addressing-byte fetch and the store write, and stops on halt or on an
// unrecognised byte. Assumes read data is valid during the clock in which
// the read strobe is high.
module bseq_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rdata,
    output logic              rd_en,
    output logic              wr_en,
    output logic              ip_step,
    output logic              stopped,
    output logic              trap
);

    import bseq_pkg::*;

    seq_state_e state_q;
    seq_state_e state_d;
    logic       bad_byte;

    // Strobes and step requests follow directly from the current cycle type.
    always_comb begin
        rd_en   = (state_q == ST_FETCH_OP) || (state_q == ST_FETCH_MODE);
        wr_en   = (state_q == ST_STORE);
        ip_step = rd_en;
        stopped = (state_q == ST_STOP);
    end

    // Decode the byte arriving at the end of a fetch and choose the next cycle.
    always_comb begin
        state_d  = state_q;
        bad_byte = 1'b0;
        case (state_q)
            ST_FETCH_OP: begin
                if (rdata == DATA_W'(OP_STORE_BYTE)) begin
                    state_d = ST_FETCH_MODE;
                end else if (rdata == DATA_W'(OP_STOP)) begin
                    state_d = ST_STOP;
                end else begin
                    state_d  = ST_STOP;
                    bad_byte = 1'b1;
                end
            end
            ST_FETCH_MODE: begin
                if (rdata == DATA_W'(MODE_AL_TO_BX)) begin
                    state_d = ST_STORE;
                end else begin
                    state_d  = ST_STOP;
                    bad_byte = 1'b1;
                end
            end
            ST_STORE: state_d = ST_FETCH_OP;
            default:  state_d = ST_STOP;
        endcase
    end

    // Cycle state register; reset restarts at an opcode fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH_OP;
        end else begin
            state_q <= state_d;
        end
    end

    // Sticky trap flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap <= 1'b0;
        end else if (bad_byte) begin
            trap <= 1'b1;
        end
    end

endmodule

// File: rtl/bytestep_seq.sv
// Top of the byte-serial fetch-execute sequencer. It joins the register
// file, two address formers (code and data) and the cycle controller. The
// bus address follows the code pointer, except in write cycles, when it
// follows DS:BX. Assumes a zero-wait-state memory.
module bytestep_seq #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  init_cs,
    input  logic [OFF_W-1:0]  init_ip,
    input  logic [SEG_W-1:0]  init_ds,
    input  logic [OFF_W-1:0]  init_bx,
    input  logic [DATA_W-1:0] init_al,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              halted,
    output logic              illegal
);

    localparam int SEG_SHIFT = ADDR_W - SEG_W;

    logic [SEG_W-1:0]  cs_q;
    logic [OFF_W-1:0]  ip_q;
    logic [SEG_W-1:0]  ds_q;
    logic [OFF_W-1:0]  bx_q;
    logic [DATA_W-1:0] al_q;
    logic [ADDR_W-1:0] code_addr;
    logic [ADDR_W-1:0] data_addr;
    logic              ip_step;

    bseq_regs #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_cs(init_cs),
        .init_ip(init_ip),
        .init_ds(init_ds),
        .init_bx(init_bx),
        .init_al(init_al),
        .ip_step(ip_step),
        .cs_q   (cs_q),
        .ip_q   (ip_q),
        .ds_q   (ds_q),
        .bx_q   (bx_q),
        .al_q   (al_q)
    );

    bseq_phys_addr #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .ADDR_W(ADDR_W),
        .SHIFT (SEG_SHIFT)
    ) u_code_addr (
        .seg (cs_q),
        .off (ip_q),
        .phys(code_addr)
    );

    bseq_phys_addr #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .ADDR_W(ADDR_W),
        .SHIFT (SEG_SHIFT)
    ) u_data_addr (
        .seg (ds_q),
        .off (bx_q),
        .phys(data_addr)
    );

    bseq_ctrl #(
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rdata  (mem_rdata),
        .rd_en  (mem_rd),
        .wr_en  (mem_wr),
        .ip_step(ip_step),
        .stopped(halted),
        .trap   (illegal)
    );

    // Bus address and write data: data pointer in write cycles, code pointer otherwise.
    always_comb begin
        mem_addr  = mem_wr ? data_addr : code_addr;
        mem_wdata = al_q;
    end

endmodule

// File: rtl/bseq_checks.sv
// Protocol checker for bytestep_seq, attached with a bind statement. It
// assumes reset is low from time zero through at least one clock edge.
module bseq_checks #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd,
    input logic              wr,
    input logic              halted,
    input logic              illegal,
    input logic [ADDR_W-1:0] addr
);

    // R11: never read and write in the same clock.
    a_r11_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));

    // R1: the first cycle after reset release is a live fetch.
    a_r1_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd && !halted && !illegal));

    // R6: a halted unit issues no bus cycles.
    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!rd && !wr));

    // R6: halt persists until reset.
    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R7: a trap always comes with halt, and persists.
    a_r7_trap_halts: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    a_r7_trap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    // R4: a write clock is directly preceded by a fetch clock.
    a_r4_write_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> $past(rd));

    // R5: a fetch follows every write clock.
    a_r5_fetch_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rd && !halted));

    // R2: the bus address holds still while halted.
    a_r2_addr_stable_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> $stable(addr));

endmodule

bind bytestep_seq bseq_checks #(
    .ADDR_W(ADDR_W)
) u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (mem_rd),
    .wr     (mem_wr),
    .halted (halted),
    .illegal(illegal),
    .addr   (mem_addr)
);

// File: tb/bytestep_seq_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural byte memory and a per-cycle reference
// model of the fetch/store/halt sequence, compared at every falling edge.
module bytestep_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] init_cs = '0;
    logic [15:0] init_ip = '0;
    logic [15:0] init_ds = '0;
    logic [15:0] init_bx = '0;
    logic [7:0]  init_al = '0;
    logic [19:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic        halted;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem_model [int];
    logic [19:0] fetch_log [$];

    // Reference model state: 0 opcode fetch, 1 mode fetch, 2 write, 3 stopped.
    int          ph = 0;
    logic [15:0] m_cs, m_ip, m_ds, m_bx;
    logic [7:0]  m_al;
    bit          m_ill = 1'b0;
    bit          run_cmp = 1'b0;
    bit          first_cyc = 1'b0;

    always #2.5 clk = ~clk;

    bytestep_seq u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_cs  (init_cs),
        .init_ip  (init_ip),
        .init_ds  (init_ds),
        .init_bx  (init_bx),
        .init_al  (init_al),
        .mem_addr (mem_addr),
        .mem_rdata(mem_rdata),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_wdata(mem_wdata),
        .halted   (halted),
        .illegal  (illegal)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return 20'(({4'b0, s} << 4) + {4'b0, o});
    endfunction

    function automatic logic [7:0] peek(input logic [19:0] a);
        return mem_model.exists(int'(a)) ? mem_model[int'(a)] : 8'h00;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory response, output comparison and model step at each falling edge.
    always @(negedge clk) begin
        logic [7:0]  b;
        logic [19:0] ea;
        mem_rdata = peek(mem_addr);
        if (run_cmp) begin
            if (first_cyc) begin
                check("R1 first cycle read strobe", 32'(mem_rd), 32'd1);
                check("R1 halted clear", 32'(halted), 32'd0);
                check("R1 illegal clear", 32'(illegal), 32'd0);
                first_cyc = 1'b0;
            end
            check("R3 read strobe", 32'(mem_rd), 32'(ph <= 1));
            check("R4 write strobe", 32'(mem_wr), 32'(ph == 2));
            check("R6 halted flag", 32'(halted), 32'(ph == 3));
            check("R7 R8 illegal flag", 32'(illegal), 32'(m_ill));
            check("R11 strobes exclusive", 32'(mem_rd && mem_wr), 32'd0);
            case (ph)
                0, 1: begin
                    ea = phys(m_cs, m_ip);
                    check("R2 R3 fetch address", 32'(mem_addr), 32'(ea));
                    fetch_log.push_back(mem_addr);
                    b = peek(ea);
                    m_ip = m_ip + 16'd1;
                    if (ph == 0) begin
                        if (b == 8'h88) ph = 1;
                        else begin
                            ph = 3;
                            if (b != 8'hF4) m_ill = 1'b1;
                        end
                    end else begin
                        if (b == 8'h07) ph = 2;
                        else begin
                            ph = 3;
                            m_ill = 1'b1;
                        end
                    end
                end
                2: begin
                    ea = phys(m_ds, m_bx);
                    check("R4 store address", 32'(mem_addr), 32'(ea));
                    check("R4 store data", 32'(mem_wdata), 32'(m_al));
                    if (mem_wr) mem_model[int'(mem_addr)] = mem_wdata;
                    ph = 0;
                end
                default: ph = 3;
            endcase
        end
    end

    task automatic run_prog(input logic [15:0] cs, input logic [15:0] ip,
                            input logic [15:0] ds, input logic [15:0] bx,
                            input logic [7:0] al);
        int n;
        @(posedge clk);
        #1;
        run_cmp = 1'b0;
        rst_n   = 1'b0;
        init_cs = cs; init_ip = ip; init_ds = ds; init_bx = bx; init_al = al;
        repeat (2) @(posedge clk);
        #1;
        m_cs = cs; m_ip = ip; m_ds = ds; m_bx = bx; m_al = al;
        ph = 0; m_ill = 1'b0;
        fetch_log.delete();
        first_cyc = 1'b1;
        rst_n   = 1'b1;
        run_cmp = 1'b1;
        n = 0;
        while (ph != 3 && n < 60) begin
            @(posedge clk);
            n++;
        end
        if (n >= 60) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=running expected=halted");
        end
        repeat (3) @(posedge clk);
        #1;
        run_cmp = 1'b0;
    endtask

    initial begin
        // Program 1: store AL to DS:BX, then halt (R4, R5, R1).
        mem_model.delete();
        mem_model[20'h10005] = 8'h88;
        mem_model[20'h10006] = 8'h07;
        mem_model[20'h10007] = 8'hF4;
        run_prog(16'h1000, 16'h0005, 16'h2000, 16'h0023, 8'h1C);
        check("R4 byte stored at 20023h", 32'(peek(20'h20023)), 32'h1C);
        check("R5 fetch count", 32'(fetch_log.size()), 32'd3);
        if (fetch_log.size() == 3) begin
            check("R5 next fetch at 10007h", 32'(fetch_log[2]), 32'h10007);
            check("R2 first fetch at 10005h", 32'(fetch_log[0]), 32'h10005);
        end
        check("R6 halted held", 32'(halted), 32'd1);

        // Program 2: two stores in a row, data address 0FFF:0010 = 10000h (R2, R5).
        mem_model.delete();
        mem_model[20'h00400] = 8'h88;
        mem_model[20'h00401] = 8'h07;
        mem_model[20'h00402] = 8'h88;
        mem_model[20'h00403] = 8'h07;
        mem_model[20'h00404] = 8'hF4;
        run_prog(16'h0040, 16'h0000, 16'h0FFF, 16'h0010, 8'h5A);
        check("R2 byte stored at 10000h", 32'(peek(20'h10000)), 32'h5A);
        check("R5 fetch count two stores", 32'(fetch_log.size()), 32'd5);

        // Program 3: IP wraps from FFFFh to 0000h (R9).
        mem_model.delete();
        mem_model[20'h0FFFF] = 8'h88;
        mem_model[20'h00000] = 8'h07;
        mem_model[20'h00001] = 8'hF4;
        run_prog(16'h0000, 16'hFFFF, 16'h3000, 16'h0000, 8'hA5);
        check("R9 fetch count", 32'(fetch_log.size()), 32'd3);
        if (fetch_log.size() == 3) begin
            check("R9 wrapped fetch address", 32'(fetch_log[1]), 32'h00000);
            check("R9 following fetch", 32'(fetch_log[2]), 32'h00001);
        end
        check("R9 byte stored at 30000h", 32'(peek(20'h30000)), 32'hA5);

        // Program 4: 20-bit address wrap on code and data (R10).
        mem_model.delete();
        mem_model[20'h00000] = 8'h88;
        mem_model[20'h00001] = 8'h07;
        mem_model[20'h00002] = 8'hF4;
        run_prog(16'hFFFF, 16'h0010, 16'hFFFF, 16'hFFFF, 8'h3C);
        if (fetch_log.size() > 0)
            check("R10 code address wraps", 32'(fetch_log[0]), 32'h00000);
        check("R10 data address wraps to 0FFEFh", 32'(peek(20'h0FFEF)), 32'h3C);

        // Program 5: unknown opcode traps (R7).
        mem_model.delete();
        mem_model[20'h05000] = 8'h90;
        run_prog(16'h0500, 16'h0000, 16'h2000, 16'h0000, 8'h11);
        check("R7 illegal set", 32'(illegal), 32'd1);
        check("R7 halted set", 32'(halted), 32'd1);
        check("R7 single fetch", 32'(fetch_log.size()), 32'd1);

        // Program 6: wrong addressing byte traps with no write (R8).
        mem_model.delete();
        mem_model[20'h05000] = 8'h88;
        mem_model[20'h05001] = 8'h06;
        mem_model[20'h20000] = 8'hEE;
        run_prog(16'h0500, 16'h0000, 16'h2000, 16'h0000, 8'h11);
        check("R8 illegal set", 32'(illegal), 32'd1);
        check("R8 two fetches", 32'(fetch_log.size()), 32'd2);
        check("R8 memory untouched", 32'(peek(20'h20000)), 32'hEE);

        // Program 7: halt right away after a trapped run; reset clears flags (R1, R6).
        mem_model.delete();
        mem_model[20'h00123] = 8'hF4;
        run_prog(16'h0012, 16'h0003, 16'h0000, 16'h0000, 8'h00);
        check("R6 halt single fetch", 32'(fetch_log.size()), 32'd1);
        check("R1 illegal cleared by reset", 32'(illegal), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule